// File: doc/BRIEF.md
# Transposing Quadrant Frame Buffer

This block holds the image for a monochrome panel of 480 by 128 pixels that is split into four quadrants of 240 by 64. It has two ports on two unrelated clocks. The host port reads and writes one byte at a time. Each byte covers eight horizontally neighbouring pixels inside one quadrant. The display port only reads. Each access returns a 4-bit word that carries the pixel at the same offset in every quadrant, so a panel driver that loads all four quadrants in parallel can fetch one word for each pixel position.

The storage is four per-quadrant arrays. Each array is written and read by the host as bytes and is read by the display one bit at a time. Both views therefore share the same bits without any format conversion. A pixel stored as 1 is dark.

The host can read back any byte, for example to toggle a cursor cell. Host column codes beyond the quadrant width are dead: writes to them are dropped and reads return zero. Display addresses beyond the last pixel also return zero.

Top module: `quad_frame_buffer`

## Requirements
- R1: A host write (`hst_sel`=1, `hst_we`=1) with host address {quadrant[12:11], row[10:5], byte column[4:0]} and byte column 0 to 29 stores `hst_wdata` in that quadrant only. The other three quadrants and all other bytes stay unchanged.
- R2: A host read (`hst_sel`=1, `hst_we`=0) of a valid address presents the stored byte on `hst_rdata` after the next `hst_clk` rising edge.
- R3: `hst_rdata` changes only as the result of a host read. It holds its value across idle cycles and across writes, including a write to the byte that was last read.
- R4: Byte column codes 30 and 31 are dead. A write to them changes no stored byte, including the first byte of the next row, and a read of them returns 0.
- R5: Display address A = row*240 + column, with column 0 to 239 inside a quadrant, selects the pixel in quadrant byte row*30 + column/8 at bit 7 - (column mod 8). Bit 7 of a host byte is the leftmost pixel.
- R6: Bit q of `dsp_pix` comes from quadrant q, where 0 is the top-left quadrant, 1 the top-right, 2 the bottom-left and 3 the bottom-right.
- R7: The display port samples `dsp_addr` on every `dsp_clk` rising edge and presents the word one `dsp_clk` cycle later. No enable is needed.
- R8: A display address of 15360 or more returns `dsp_pix` = 0.
- R9: While `rst_n` is low, `hst_rdata` and `dsp_pix` are 0. Reset asserts asynchronously and is released separately in each clock domain after two edges of that domain's clock. Stored pixels are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hst_clk | input | 1 | Host port clock |
| dsp_clk | input | 1 | Display port clock, unrelated to the host clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| hst_sel | input | 1 | Host access request for this cycle |
| hst_we | input | 1 | 1 = write, 0 = read, qualified by hst_sel |
| hst_addr | input | 13 | {quadrant, row, byte column} |
| hst_wdata | input | 8 | Write byte, bit 7 = leftmost pixel |
| hst_rdata | output | 8 | Read byte, registered |
| dsp_addr | input | 14 | Pixel index within a quadrant, row*240+column |
| dsp_pix | output | 4 | One pixel per quadrant, bit q = quadrant q |

## Verification
A host read result is due one `hst_clk` edge after the request. The bench drives the request on a falling edge and samples `hst_rdata` on the next falling edge, which falls after exactly one capturing rising edge. A display word is due one `dsp_clk` edge after its address. The bench uses the same falling-edge drive-and-sample pattern on `dsp_clk`. Display reads of freshly written bytes start only after the host write edge has passed, so the write is already visible when the display address is captured. Hold checks for R3 sample `hst_rdata` again after idle cycles and after a write, with no read in between.

// File: rtl/qfb_pkg.sv
`timescale 1ns/1ps
package qfb_pkg;
  localparam int NQUAD = 4;
  localparam int PIX_PER_BYTE = 8;
  typedef logic [1:0] quad_t;
endpackage

// File: rtl/qfb_rst_sync.sv
`timescale 1ns/1ps
module qfb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/qfb_host_decode.sv
`timescale 1ns/1ps
module qfb_host_decode
  import qfb_pkg::*;
#(
  parameter int ROW_W   = 6,
  parameter int COL_W   = 5,
  parameter int BPR     = 30,
  parameter int IDX_W   = 11,
  localparam int HADDR_W = 2 + ROW_W + COL_W
) (
  input  logic               sel,
  input  logic               we,
  input  logic [HADDR_W-1:0] addr,
  output logic [NQUAD-1:0]   wr_vec,
  output logic [NQUAD-1:0]   rd_vec,
  output logic               rd_go,
  output logic               col_ok,
  output quad_t              quad,
  output logic [IDX_W-1:0]   idx
);
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] bcol;

  always_comb begin
    quad   = addr[HADDR_W-1 -: 2];
    row    = addr[COL_W +: ROW_W];
    bcol   = addr[COL_W-1:0];
    col_ok = (int'(bcol) < BPR);
    idx    = IDX_W'(int'(row) * BPR + int'(bcol));
    rd_go  = sel & ~we;
    for (int q = 0; q < NQUAD; q++) begin
      wr_vec[q] = sel & we & col_ok & (quad == quad_t'(q));
      rd_vec[q] = rd_go & col_ok & (quad == quad_t'(q));
    end
  end
endmodule

// File: rtl/qfb_quad_ram.sv
`timescale 1ns/1ps
module qfb_quad_ram
  import qfb_pkg::*;
#(
  parameter int DEPTH = 1920,
  parameter int IDX_W = 11
) (
  input  logic                    h_clk,
  input  logic                    h_rst_n,
  input  logic                    h_we,
  input  logic                    h_re,
  input  logic [IDX_W-1:0]        h_idx,
  input  logic [PIX_PER_BYTE-1:0] h_wbyte,
  output logic [PIX_PER_BYTE-1:0] h_rbyte,
  input  logic                    d_clk,
  input  logic                    d_rst_n,
  input  logic [IDX_W-1:0]        d_idx,
  input  logic [2:0]              d_bsel,
  output logic                    d_bit
);
  logic [PIX_PER_BYTE-1:0] mem [DEPTH];
  logic [PIX_PER_BYTE-1:0] h_rbyte_d;
  logic                    d_bit_d;
  logic [2:0]              bitpos;

  // Host side: byte-wide storage update, no reset on array contents
  always_ff @(posedge h_clk) begin
    if (h_we) mem[h_idx] <= h_wbyte;
  end

  always_comb begin
    h_rbyte_d = h_re ? mem[h_idx] : h_rbyte;
  end

  always_ff @(posedge h_clk or negedge h_rst_n) begin
    if (!h_rst_n) h_rbyte <= '0;
    else          h_rbyte <= h_rbyte_d;
  end

  // Display side: leftmost pixel lives in bit 7, so position = 7 - offset
  always_comb begin
    bitpos  = ~d_bsel;
    d_bit_d = mem[d_idx][bitpos];
  end

  always_ff @(posedge d_clk or negedge d_rst_n) begin
    if (!d_rst_n) d_bit <= 1'b0;
    else          d_bit <= d_bit_d;
  end

  // R1
  wr_in_range_chk: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    h_we |-> (int'(h_idx) < DEPTH));

  // R2
  no_rw_clash_chk: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    !(h_we && h_re));
endmodule

// File: rtl/quad_frame_buffer.sv
`timescale 1ns/1ps
module quad_frame_buffer
  import qfb_pkg::*;
#(
  parameter int QUAD_W = 240,
  parameter int QUAD_H = 64,
  localparam int BPR     = QUAD_W / PIX_PER_BYTE,
  localparam int DEPTH   = BPR * QUAD_H,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int ROW_W   = $clog2(QUAD_H),
  localparam int COL_W   = $clog2(BPR),
  localparam int HADDR_W = 2 + ROW_W + COL_W,
  localparam int NPIX    = QUAD_W * QUAD_H,
  localparam int DADDR_W = $clog2(NPIX)
) (
  input  logic               hst_clk,
  input  logic               dsp_clk,
  input  logic               rst_n,
  input  logic               hst_sel,
  input  logic               hst_we,
  input  logic [HADDR_W-1:0] hst_addr,
  input  logic [7:0]         hst_wdata,
  output logic [7:0]         hst_rdata,
  input  logic [DADDR_W-1:0] dsp_addr,
  output logic [NQUAD-1:0]   dsp_pix
);
  logic              h_rst_n;
  logic              d_rst_n;
  logic [NQUAD-1:0]  wr_vec;
  logic [NQUAD-1:0]  rd_vec;
  logic              rd_go;
  logic              col_ok;
  quad_t             quad;
  logic [IDX_W-1:0]  h_idx;
  logic [7:0]        rbyte [NQUAD];
  logic [NQUAD-1:0]  dbit;

  logic              rq_ok_q, rq_ok_d;
  quad_t             rq_quad_q, rq_quad_d;
  logic              d_ok, d_ok_q;
  logic [IDX_W-1:0]  d_idx;

  qfb_rst_sync u_hrst (.clk(hst_clk), .arst_n(rst_n), .srst_n(h_rst_n));
  qfb_rst_sync u_drst (.clk(dsp_clk), .arst_n(rst_n), .srst_n(d_rst_n));

  qfb_host_decode #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BPR(BPR), .IDX_W(IDX_W)
  ) u_dec (
    .sel(hst_sel), .we(hst_we), .addr(hst_addr),
    .wr_vec(wr_vec), .rd_vec(rd_vec), .rd_go(rd_go),
    .col_ok(col_ok), .quad(quad), .idx(h_idx)
  );

  // Display address decode: byte index is address / 8 because BPR*8 = QUAD_W
  always_comb begin
    d_ok  = (int'(dsp_addr) < NPIX);
    d_idx = d_ok ? IDX_W'(dsp_addr >> 3) : '0;
  end

  for (genvar q = 0; q < NQUAD; q++) begin : g_quad
    qfb_quad_ram #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
      .h_clk(hst_clk), .h_rst_n(h_rst_n),
      .h_we(wr_vec[q]), .h_re(rd_vec[q]),
      .h_idx(h_idx), .h_wbyte(hst_wdata), .h_rbyte(rbyte[q]),
      .d_clk(dsp_clk), .d_rst_n(d_rst_n),
      .d_idx(d_idx), .d_bsel(dsp_addr[2:0]), .d_bit(dbit[q])
    );
  end

  // Host read bookkeeping, enabled by a read request only
  always_comb begin
    rq_ok_d   = rq_ok_q;
    rq_quad_d = rq_quad_q;
    if (rd_go) begin
      rq_ok_d   = col_ok;
      rq_quad_d = quad;
    end
  end

  always_ff @(posedge hst_clk or negedge h_rst_n) begin
    if (!h_rst_n) begin
      rq_ok_q   <= 1'b0;
      rq_quad_q <= '0;
    end else begin
      rq_ok_q   <= rq_ok_d;
      rq_quad_q <= rq_quad_d;
    end
  end

  always_comb begin
    hst_rdata = rq_ok_q ? rbyte[rq_quad_q] : 8'h00;
  end

  always_ff @(posedge dsp_clk or negedge d_rst_n) begin
    if (!d_rst_n) d_ok_q <= 1'b0;
    else          d_ok_q <= d_ok;
  end

  always_comb begin
    dsp_pix = d_ok_q ? dbit : '0;
  end

  // R1
  one_quad_write_chk: assert property (@(posedge hst_clk) disable iff (!h_rst_n)
    $onehot0(wr_vec));

  // R3
  rdata_hold_chk: assert property (@(posedge hst_clk) disable iff (!h_rst_n)
    !(hst_sel && !hst_we) |=> $stable(hst_rdata));

  // R4
  dead_col_read_chk: assert property (@(posedge hst_clk) disable iff (!h_rst_n)
    (hst_sel && !hst_we && (int'(hst_addr[COL_W-1:0]) >= BPR)) |=> (hst_rdata == 8'h00));

  // R8
  dsp_oob_zero_chk: assert property (@(posedge dsp_clk) disable iff (!d_rst_n)
    (int'(dsp_addr) >= NPIX) |=> (dsp_pix == '0));
endmodule

// File: tb/sim_quad_frame_buffer.sv
`timescale 1ns/1ps
module sim_quad_frame_buffer;
  logic        hst_clk = 1'b0;
  logic        dsp_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        hst_sel = 1'b0;
  logic        hst_we  = 1'b0;
  logic [12:0] hst_addr = '0;
  logic [7:0]  hst_wdata = '0;
  logic [7:0]  hst_rdata;
  logic [13:0] dsp_addr = '0;
  logic [3:0]  dsp_pix;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4  hst_clk = ~hst_clk;
  always #40 dsp_clk = ~dsp_clk;

  quad_frame_buffer u0 (
    .hst_clk(hst_clk), .dsp_clk(dsp_clk), .rst_n(rst_n),
    .hst_sel(hst_sel), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .dsp_addr(dsp_addr), .dsp_pix(dsp_pix)
  );

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] haddr(int q, int row, int bc);
    return {2'(q), 6'(row), 5'(bc)};
  endfunction

  task automatic hwrite(int q, int row, int bc, logic [7:0] d);
    @(negedge hst_clk);
    hst_sel = 1; hst_we = 1; hst_addr = haddr(q, row, bc); hst_wdata = d;
    @(negedge hst_clk);
    hst_sel = 0; hst_we = 0;
  endtask

  task automatic hread(int q, int row, int bc, output logic [7:0] d);
    @(negedge hst_clk);
    hst_sel = 1; hst_we = 0; hst_addr = haddr(q, row, bc);
    @(negedge hst_clk);
    hst_sel = 0;
    d = hst_rdata;
  endtask

  task automatic dread(int a, output logic [3:0] p);
    @(negedge dsp_clk);
    dsp_addr = 14'(a);
    @(negedge dsp_clk);
    p = dsp_pix;
  endtask

  task automatic t_reset();
    check("R9 hst_rdata in reset", hst_rdata, 0);
    check("R9 dsp_pix in reset", dsp_pix, 0);
  endtask

  task automatic t_host_rw();
    logic [7:0] d;
    hwrite(0, 0, 0, 8'hA5);
    hwrite(1, 10, 7, 8'h3C);
    hwrite(2, 33, 12, 8'hF0);
    hwrite(3, 63, 29, 8'h81);
    hread(0, 0, 0, d);   check("R2 read q0", d, 8'hA5);
    hread(1, 10, 7, d);  check("R2 read q1", d, 8'h3C);
    hread(2, 33, 12, d); check("R2 read q2", d, 8'hF0);
    hread(3, 63, 29, d); check("R2 read q3 last byte", d, 8'h81);
  endtask

  task automatic t_quad_isolation();
    logic [7:0] d;
    for (int q = 0; q < 4; q++) hwrite(q, 20, 4, 8'(8'h10 + q));
    hwrite(2, 20, 4, 8'hEE);
    for (int q = 0; q < 4; q++) begin
      hread(q, 20, 4, d);
      check("R1 quadrant isolation", d, (q == 2) ? 8'hEE : 8'h10 + q);
    end
  endtask

  task automatic t_dead_cols();
    logic [7:0] d;
    hwrite(0, 6, 0, 8'h5A);
    hwrite(0, 5, 30, 8'hFF);
    hwrite(1, 6, 1, 8'h77);
    hwrite(1, 5, 31, 8'h00);
    hread(0, 6, 0, d);  check("R4 dead col write aliased", d, 8'h5A);
    hread(1, 6, 1, d);  check("R4 dead col 31 write aliased", d, 8'h77);
    hread(0, 5, 30, d); check("R4 dead col read", d, 0);
    hread(1, 5, 31, d); check("R4 dead col 31 read", d, 0);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    hwrite(3, 40, 9, 8'hC3);
    hread(3, 40, 9, d); check("R2 read before hold", d, 8'hC3);
    repeat (5) @(negedge hst_clk);
    check("R3 hold idle", hst_rdata, 8'hC3);
    hwrite(3, 40, 9, 8'h18);
    @(negedge hst_clk);
    check("R3 hold over write", hst_rdata, 8'hC3);
  endtask

  task automatic t_display_bits();
    logic [3:0] p;
    hwrite(0, 5, 3, 8'b1000_0001);
    hwrite(1, 5, 3, 8'b0100_0000);
    hwrite(2, 5, 3, 8'b1100_0000);
    hwrite(3, 5, 3, 8'b0000_0001);
    dread(5*240 + 24, p); check("R5 R6 leftmost pixel", p, 4'b0101);
    dread(5*240 + 25, p); check("R5 R6 second pixel", p, 4'b0110);
    dread(5*240 + 31, p); check("R5 R6 rightmost pixel", p, 4'b1001);
    dread(5*240 + 27, p); check("R5 blank pixel", p, 4'b0000);
  endtask

  task automatic t_placement();
    logic [3:0] p;
    int qx, qy, q;
    // pixel at panel (x=250, y=70): quadrant = {y>=64, x>=240}
    qx = (250 >= 240) ? 1 : 0;
    qy = (70 >= 64) ? 1 : 0;
    q  = qy * 2 + qx;
    hwrite(q, 70 - 64, (250 - 240) / 8, 8'h80 >> ((250 - 240) % 8));
    dread((70 - 64) * 240 + (250 - 240), p);
    check("R6 panel placement bottom-right", p & (4'b1 << q), 4'b1 << q);
    hwrite(0, 63, 29, 8'h01);
    dread(15359, p); check("R5 last display pixel", p[0], 1);
  endtask

  task automatic t_dsp_stream();
    logic [3:0] p;
    dread(15360, p); check("R8 out of range 15360", p, 0);
    dread(16383, p); check("R8 out of range max", p, 0);
    @(negedge dsp_clk);
    dsp_addr = 14'(5*240 + 24);
    @(negedge dsp_clk);
    check("R7 first streamed word", dsp_pix, 4'b0101);
    dsp_addr = 14'(5*240 + 31);
    @(negedge dsp_clk);
    check("R7 next streamed word", dsp_pix, 4'b1001);
  endtask

  task automatic t_reset_keeps_data();
    logic [7:0] d;
    @(negedge hst_clk);
    rst_n = 0;
    #1;
    check("R9 async reset rdata", hst_rdata, 0);
    check("R9 async reset pix", dsp_pix, 0);
    repeat (3) @(negedge dsp_clk);
    rst_n = 1;
    repeat (4) @(negedge dsp_clk);
    hread(0, 0, 0, d); check("R9 contents survive reset", d, 8'hA5);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge dsp_clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge dsp_clk);
    t_host_rw();
    t_quad_isolation();
    t_dead_cols();
    t_hold();
    t_display_bits();
    t_placement();
    t_dsp_stream();
    t_reset_keeps_data();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule